// File: doc/BRIEF.md
# Vectored IRQ/FIQ Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines into a latching pending register. It filters them through a per-source mask, and a per-source mode bit sends each one either to the normal interrupt path or to the fast interrupt path. Normal-path candidates are resolved in two levels. Six group arbiters each choose a local winner. A final arbiter then picks among the group winners with a fixed order. The overall winner is captured into a one-hot in-service register, and its index is kept in an offset register. The processor sees two lines: `irq_o`, high while a source is in service, and `fiq_o`, high while any unmasked fast-mode source is pending.

Software reaches every register through a flat single-cycle register port. A write to the register port takes effect at the next clock edge. Reads are combinational on the address. A service routine reads the offset register to find the source. It then clears that source's pending bit and its in-service bit. Once the in-service register is empty, the controller captures the next winner on the following edge.

Group g covers source indices 6g-2 to 6g+3, clipped to 0..31. Source index 6g-2+k sits in slot k of its group. Group 0 therefore uses slots 2..5 for sources 0..3, and group 5 uses slots 0..3 for sources 28..31.

Top module: `vic_ctrl`

## Requirements
- R1: When `src_i[n]` is high at a clock edge, pending bit n is set after that edge. Several bits may be set together, and the pending register reads back at address 0.
- R2: Writing to address 0 clears each pending bit whose write-data bit is 1. If the source is high in the same cycle, the bit stays set.
- R3: The mask register (address 1) resets to 0xFFFFFFFF. A masked source (bit = 1) never enters service and never drives `fiq_o`, but it still records in pending.
- R4: The mode register (address 2) resets to 0. A source with mode bit 1 that is pending and unmasked drives `fiq_o` high and never enters the in-service register.
- R5: The in-service register (address 4) has at most one bit set. A new winner is captured one edge after the in-service register is seen empty, and only when that register is empty.
- R6: Writing 1 to an in-service bit clears it, and `irq_o` falls after that edge. Writing 0, or writing 1 to a bit that is not set, changes nothing. `irq_o` is high exactly while a bit is in service.
- R7: The offset register (address 5, read-only) holds the binary index of the in-service source. It reads 0 when nothing is in service.
- R8: Between groups, the lower group number always wins, whatever the slot positions inside the groups.
- R9: Within a group, slot 0 always ranks first and slot 5 always ranks last. The middle slots rank in the order 1+((s+j) mod 4) for j = 0..3, where s is the group's 2-bit order select.
- R10: The priority register (address 3) holds rotate-enable bits [5:0], one per group, and the 2-bit order select of group g at bits [7+2g:6+2g]. It resets to 0. When a winner from group g is captured and g's rotate bit is 1, g's select increments and wraps from 3 to 0. Otherwise the select is unchanged.
- R11: Reads at addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt request lines, level sensitive |
| bus_addr_i | input | 3 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Normal interrupt request to processor |
| fiq_o | output | 1 | Fast interrupt request to processor |

## Verification
The bench holds a source high while it clears that same pending bit. A controller that let the clear win would lose the request. It raises sources from different groups together, including group 0's lowest slot against a higher slot in group 1. A design that ranked by raw index, or by slot instead of by group, would pick the wrong winner. It steps the rotating order select through a full wrap and compares the winners and the select values read back against the rotated order, which exposes an off-by-one in the order or a failure to wrap. It also writes zeros and foreign bits to the in-service register and checks that service continues. A routed fast source is checked to raise `fiq_o` without reaching the in-service register. A controller that captured a new winner while one was still in service, or that let a fast source into arbitration, would show it in the offset readout.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSRC      = 32;
    localparam int NGRP      = 6;
    localparam int GSLOTS    = 6;
    localparam int FIRST_OFS = 2;
    localparam int SRC_W     = $clog2(NSRC);
    localparam int GRP_W     = $clog2(NGRP);
    localparam int SLOT_W    = $clog2(GSLOTS);
    localparam int SEL_W     = $clog2(GSLOTS - 2);
    localparam int PRIO_W    = NGRP + NGRP * SEL_W;
    localparam int DW        = 32;
    localparam int AW        = 3;

    localparam logic [AW-1:0] A_PEND = 3'd0;
    localparam logic [AW-1:0] A_MASK = 3'd1;
    localparam logic [AW-1:0] A_MODE = 3'd2;
    localparam logic [AW-1:0] A_PRIO = 3'd3;
    localparam logic [AW-1:0] A_INSV = 3'd4;
    localparam logic [AW-1:0] A_OFFS = 3'd5;

    typedef struct packed {
        logic [NSRC-1:0]   pend;
        logic [NSRC-1:0]   mask;
        logic [NSRC-1:0]   mode;
        logic [PRIO_W-1:0] prio;
        logic [NSRC-1:0]   insv;
        logic [SRC_W-1:0]  offs;
    } vic_state_t;
endpackage

// File: rtl/vic_grp_arb.sv
module vic_grp_arb #(
    parameter int SLOTS  = 6,
    parameter int SEL_W  = $clog2(SLOTS - 2),
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0]  req_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              hit_o,
    output logic [SLOT_W-1:0] slot_o
);
    localparam int MID = SLOTS - 2;

    logic found;

    always_comb begin
        hit_o  = |req_i;
        slot_o = '0;
        found  = 1'b0;
        if (req_i[0]) begin
            found = 1'b1;
        end
        for (int j = 0; j < MID; j++) begin
            if (!found && req_i[1 + ((int'(sel_i) + j) % MID)]) begin
                slot_o = SLOT_W'(1 + ((int'(sel_i) + j) % MID));
                found  = 1'b1;
            end
        end
        if (!found && req_i[SLOTS-1]) begin
            slot_o = SLOT_W'(SLOTS - 1);
        end
    end
endmodule

// File: rtl/vic_fin_arb.sv
module vic_fin_arb #(
    parameter int N   = 6,
    parameter int IDW = $clog2(N)
) (
    input  logic [N-1:0]   req_i,
    output logic           hit_o,
    output logic [IDW-1:0] grp_o
);
    always_comb begin
        hit_o = |req_i;
        grp_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) grp_o = IDW'(i);
        end
    end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [31:0]   src_i,
    input  logic [2:0]    bus_addr_i,
    input  logic          bus_we_i,
    input  logic [31:0]   bus_wdata_i,
    output logic [31:0]   bus_rdata_o,
    output logic          irq_o,
    output logic          fiq_o
);
    vic_state_t st_d, st_q;

    logic [NSRC-1:0]   cand;
    logic [NSRC-1:0]   pend_q, mask_q, mode_q, insv_q;
    logic [SRC_W-1:0]  offs_q;
    logic [NGRP-1:0][GSLOTS-1:0] grp_req;
    logic [NGRP-1:0][SLOT_W-1:0] grp_slot;
    logic [NGRP-1:0]   grp_hit;
    logic              fin_hit;
    logic [GRP_W-1:0]  fin_grp;
    logic [SRC_W-1:0]  win_idx;
    logic [SEL_W-1:0]  cur_sel;
    int                win_int;

    assign pend_q = st_q.pend;
    assign mask_q = st_q.mask;
    assign mode_q = st_q.mode;
    assign insv_q = st_q.insv;
    assign offs_q = st_q.offs;

    assign cand = st_q.pend & ~st_q.mask & ~st_q.mode;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        for (genvar k = 0; k < GSLOTS; k++) begin : g_slot
            localparam int IDX = g * GSLOTS - FIRST_OFS + k;
            if (IDX >= 0 && IDX < NSRC) begin : g_on
                assign grp_req[g][k] = cand[IDX];
            end else begin : g_off
                assign grp_req[g][k] = 1'b0;
            end
        end
        vic_grp_arb #(.SLOTS(GSLOTS), .SEL_W(SEL_W), .SLOT_W(SLOT_W)) u_arb (
            .req_i  (grp_req[g]),
            .sel_i  (st_q.prio[NGRP + SEL_W*g +: SEL_W]),
            .hit_o  (grp_hit[g]),
            .slot_o (grp_slot[g])
        );
    end

    vic_fin_arb #(.N(NGRP), .IDW(GRP_W)) u_fin (
        .req_i (grp_hit),
        .hit_o (fin_hit),
        .grp_o (fin_grp)
    );

    always_comb begin
        win_int = int'(fin_grp) * GSLOTS - FIRST_OFS + int'(grp_slot[fin_grp]);
        win_idx = SRC_W'(win_int);
    end

    always_comb begin
        st_d    = st_q;
        cur_sel = '0;
        if (bus_we_i) begin
            case (bus_addr_i)
                A_PEND:  st_d.pend = st_q.pend & ~bus_wdata_i;
                A_MASK:  st_d.mask = bus_wdata_i;
                A_MODE:  st_d.mode = bus_wdata_i;
                A_PRIO:  st_d.prio = bus_wdata_i[PRIO_W-1:0];
                A_INSV:  st_d.insv = st_q.insv & ~bus_wdata_i;
                default: ;
            endcase
        end
        st_d.pend = st_d.pend | src_i;
        if (st_q.insv == '0 && fin_hit) begin
            st_d.insv = NSRC'(1) << win_idx;
            st_d.offs = win_idx;
            if (st_q.prio[fin_grp]) begin
                cur_sel = st_d.prio[NGRP + SEL_W*int'(fin_grp) +: SEL_W];
                st_d.prio[NGRP + SEL_W*int'(fin_grp) +: SEL_W] = cur_sel + SEL_W'(1);
            end
        end else if (st_d.insv == '0) begin
            st_d.offs = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q      <= st_d;
        end
    end

    always_comb begin
        case (bus_addr_i)
            A_PEND:  bus_rdata_o = st_q.pend;
            A_MASK:  bus_rdata_o = st_q.mask;
            A_MODE:  bus_rdata_o = st_q.mode;
            A_PRIO:  bus_rdata_o = DW'(st_q.prio);
            A_INSV:  bus_rdata_o = st_q.insv;
            A_OFFS:  bus_rdata_o = DW'(st_q.offs);
            default: bus_rdata_o = '0;
        endcase
    end

    assign irq_o = |st_q.insv;
    assign fiq_o = |(st_q.pend & ~st_q.mask & st_q.mode);
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk
    import vic_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NSRC-1:0]   src_i,
    input logic [AW-1:0]     bus_addr_i,
    input logic              bus_we_i,
    input logic [DW-1:0]     bus_wdata_i,
    input logic [NSRC-1:0]   pend,
    input logic [NSRC-1:0]   mask,
    input logic [NSRC-1:0]   mode,
    input logic [NSRC-1:0]   insv,
    input logic [SRC_W-1:0]  offs,
    input logic              irq_o
);
    a_r1_pend_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_i != '0) |=> ((pend & $past(src_i)) == $past(src_i)));

    a_r5_insv_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(insv));

    a_r4_winner_is_irq_cand: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insv == '0) |=> (insv == '0 || (insv & $past(pend & ~mask & ~mode)) == insv));

    a_r6_insv_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insv != '0 && !(bus_we_i && bus_addr_i == A_INSV)) |=> (insv == $past(insv)));

    a_r6_irq_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insv != '0 && bus_we_i && bus_addr_i == A_INSV && (bus_wdata_i & insv) == insv) |=> !irq_o);

    a_r7_offs_points: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insv != '0) |-> insv[offs]);

    a_r7_offs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insv == '0) |-> (offs == '0));
endmodule

bind vic_ctrl vic_ctrl_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_i),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .pend        (pend_q),
    .mask        (mask_q),
    .mode        (mode_q),
    .insv        (insv_q),
    .offs        (offs_q),
    .irq_o       (irq_o)
);

// File: tb/vic_ctrl_bench.sv
module vic_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] src_i = '0;
    logic [2:0]  bus_addr_i = '0;
    logic        bus_we_i = 1'b0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        irq_o, fiq_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    vic_ctrl u_vic_ctrl (
        .clk_i(clk), .rst_ni(rst_ni), .src_i(src_i),
        .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_ni = 1'b0; src_i = '0; bus_we_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
        @(negedge clk);
        bus_we_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr_i = a;
        #1;
        d = bus_rdata_o;
    endtask

    task automatic pulse(input logic [31:0] m);
        src_i = m;
        @(negedge clk);
        src_i = '0;
    endtask

    task automatic svc(input int n);
        wr(3'd0, 32'h1 << n);
        wr(3'd4, 32'h1 << n);
    endtask

    task automatic expect_win(input string tag, input int n);
        logic [31:0] v;
        rd(3'd4, v); chk({tag, " insv"}, v, 32'h1 << n);
        rd(3'd5, v); chk({tag, " offs"}, v, n);
        chk({tag, " irq"}, {31'd0, irq_o}, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(3'd0, v); chk("R1 pend reset", v, 0);
        rd(3'd1, v); chk("R3 mask reset", v, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R4 mode reset", v, 0);
        rd(3'd3, v); chk("R10 prio reset", v, 0);
        rd(3'd4, v); chk("R5 insv reset", v, 0);
        rd(3'd5, v); chk("R7 offs reset", v, 0);
        chk("R6 irq reset", {31'd0, irq_o}, 0);
        chk("R4 fiq reset", {31'd0, fiq_o}, 0);
    endtask

    task automatic t_masked();
        logic [31:0] v;
        do_reset();
        pulse((32'h1 << 10) | (32'h1 << 20));
        @(negedge clk);
        rd(3'd0, v); chk("R1 pend multi", v, (32'h1 << 10) | (32'h1 << 20));
        rd(3'd4, v); chk("R3 masked no service", v, 0);
        chk("R3 masked no irq", {31'd0, irq_o}, 0);
        wr(3'd0, 32'h1 << 10);
        rd(3'd0, v); chk("R2 pend w1c", v, 32'h1 << 20);
        rd(3'd7, v); chk("R11 unmapped read", v, 0);
        rd(3'd6, v); chk("R11 unmapped read 6", v, 0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        do_reset();
        src_i = 32'h1 << 5;
        @(negedge clk);
        wr(3'd0, 32'h1 << 5);
        rd(3'd0, v); chk("R2 clear vs set", v, 32'h1 << 5);
        src_i = '0;
        wr(3'd0, 32'h1 << 5);
        rd(3'd0, v); chk("R2 clear after drop", v, 0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        do_reset();
        wr(3'd1, 32'h0);
        pulse((32'h1 << 10) | (32'h1 << 12) | (32'h1 << 28));
        @(negedge clk);
        expect_win("R8 R5 first", 10);
        svc(10);
        chk("R6 irq falls", {31'd0, irq_o}, 0);
        rd(3'd5, v); chk("R7 offs idle", v, 0);
        @(negedge clk);
        expect_win("R5 second", 12);
        wr(3'd4, 32'h0);
        rd(3'd4, v); chk("R6 write zero", v, 32'h1 << 12);
        wr(3'd4, 32'h1 << 5);
        rd(3'd4, v); chk("R6 foreign bit", v, 32'h1 << 12);
        svc(12);
        @(negedge clk);
        expect_win("R7 third", 28);
        svc(28);
        @(negedge clk);
        rd(3'd4, v); chk("R5 drained", v, 0);
        chk("R6 irq idle", {31'd0, irq_o}, 0);
    endtask

    task automatic t_fiq();
        logic [31:0] v;
        do_reset();
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h1 << 3);
        pulse(32'h1 << 3);
        chk("R4 fiq high", {31'd0, fiq_o}, 1);
        @(negedge clk);
        rd(3'd4, v); chk("R4 fiq not served", v, 0);
        chk("R4 no irq", {31'd0, irq_o}, 0);
        wr(3'd1, 32'h1 << 3);
        chk("R3 masked fiq", {31'd0, fiq_o}, 0);
    endtask

    task automatic t_groups();
        logic [31:0] v;
        do_reset();
        wr(3'd1, 32'h0);
        pulse((32'h1 << 3) | (32'h1 << 4));
        @(negedge clk);
        expect_win("R8 group0 beats group1", 3);

        do_reset();
        wr(3'd1, 32'h0);
        pulse((32'h1 << 11) | (32'h1 << 12));
        @(negedge clk);
        expect_win("R9 sel0", 11);

        do_reset();
        wr(3'd1, 32'h0);
        wr(3'd3, 32'h1 << 10);
        pulse((32'h1 << 11) | (32'h1 << 12));
        @(negedge clk);
        expect_win("R9 sel1", 12);

        do_reset();
        wr(3'd1, 32'h0);
        wr(3'd3, 32'h3 << 10);
        pulse((32'h1 << 10) | (32'h1 << 11) | (32'h1 << 15));
        @(negedge clk);
        expect_win("R9 slot0 first", 10);
        svc(10);
        @(negedge clk);
        expect_win("R9 sel3 middle", 11);
        svc(11);
        @(negedge clk);
        expect_win("R9 slot5 last", 15);
        rd(3'd3, v); chk("R10 no rotate", v, 32'h3 << 10);
    endtask

    task automatic t_rotate();
        logic [31:0] v;
        do_reset();
        wr(3'd1, 32'h0);
        wr(3'd3, 32'h1 << 2);
        pulse((32'h1 << 11) | (32'h1 << 12));
        @(negedge clk);
        expect_win("R10 rot a", 11);
        rd(3'd3, v); chk("R10 sel 1", v, (32'h1 << 2) | (32'h1 << 10));
        svc(11);
        @(negedge clk);
        expect_win("R10 rot b", 12);
        rd(3'd3, v); chk("R10 sel 2", v, (32'h1 << 2) | (32'h2 << 10));
        svc(12);
        pulse((32'h1 << 11) | (32'h1 << 12));
        @(negedge clk);
        expect_win("R10 rot c", 11);
        rd(3'd3, v); chk("R10 sel 3", v, (32'h1 << 2) | (32'h3 << 10));
        svc(11);
        @(negedge clk);
        expect_win("R10 rot d", 12);
        rd(3'd3, v); chk("R10 sel wrap", v, 32'h1 << 2);
    endtask

    initial begin
        t_reset();
        t_masked();
        t_race();
        t_basic();
        t_fiq();
        t_groups();
        t_rotate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule